// File: doc/BRIEF.md
# Dual Interval Timer with Wrap-to-One Counters

This block holds two independent interval timers behind a small 32-bit register bus. Each timer has a counter that steps once per microsecond tick and a limit. When the next counter value would reach the limit, the counter restarts at 1 and a sticky limit-reached flag is set. The flag drives a level interrupt. The first channel drives the level-10 interrupt output and the second drives the level-14 output.

Both the count and the limit sit in bits 30:10 of a bus word, and bit 31 carries the limit-reached flag. Because the counter restarts at 1, a limit of N gives a period of N-1 ticks, so software programs one more than the period it wants. A limit can be written in two ways: the normal address restarts the counter, and a second address swaps in a new limit and leaves the running count alone. A limit of zero stops the channel. Two plain 32-bit words, a control word and a configuration word, complete the map.

Top module: `interval_timer_pair`

## Requirements
- R1: After reset, the level-14 limit word reads 0x009C4000. The level-10 limit word, control and config read 0. Both count words read 0x00000400 (count 1), and both interrupts are low.
- R2: With a non-zero limit, the count field (bits 30:10) rises by one on each cycle where tick_us is high, and holds when tick_us is low.
- R3: On a tick where count+1 is greater than or equal to the limit, the count becomes 1 and the flag is set, so a limit of N repeats every N-1 ticks. The channel's interrupt output equals its flag.
- R4: Count and limit reads return the flag in bit 31, the field in bits 30:10, and zeros in bits 9:0. Written bits 31 and 9:0 are ignored.
- R5: A read at the channel's limit address clears the flag and the interrupt from the next cycle. A wrap in that same cycle wins and leaves the flag set.
- R6: A write to the limit address loads the limit, sets the count to 1 and clears the flag, with priority over a tick in the same cycle.
- R7: A write to the keep-count limit address loads the limit only. The count continues from its value under the old limit and the flag is unchanged.
- R8: While a channel's limit is zero, its count holds and its flag is never set, whatever tick_us does.
- R9: The two channels are independent. Word addresses are 0 (limit), 1 (count) and 2 (keep-count limit) for level 10, and 3, 4 and 5 for level 14. irq_l10 and irq_l14 follow the respective flags.
- R10: Address 6 (control) and address 7 (config) store and return full 32-bit writes. Writes to count addresses are ignored. Keep-count limit addresses read 0, and a read at a count address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_us | input | 1 | One-cycle pulse per microsecond, advances counters |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational in the access cycle |
| irq_l10 | output | 1 | Level interrupt of channel 0 |
| irq_l14 | output | 1 | Level interrupt of channel 1 |

## Verification
The hardest cases to reach are a wrap that lands in the same cycle as a limit read or a limit rewrite, and a keep-count write that drops the limit below the running count. These depend on the tick phase and the limit value lining up at one exact cycle. The bench sweeps every small limit against several tick patterns while reading every cycle, alternating between count and limit reads. Many of those reads therefore coincide with wraps. A cycle-accurate arithmetic model in the bench predicts each read word and each interrupt level.

// File: rtl/itp_pkg.sv
package itp_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 3;
    localparam int NCH       = 2;
    localparam int CH_STRIDE = 3;
    localparam int OFS_LIMIT = 0;
    localparam int OFS_COUNT = 1;
    localparam int OFS_KEEP  = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd6;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd7;
endpackage

// File: rtl/itp_channel.sv
module itp_channel #(
    parameter int FW = 21,
    parameter logic [FW-1:0] RST_LIM = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_lim,
    input  logic          wr_keep,
    input  logic          rd_lim,
    input  logic [FW-1:0] wr_val,
    output logic [FW-1:0] cnt_o,
    output logic [FW-1:0] lim_o,
    output logic          flag_o
);
    typedef struct packed {
        logic [FW-1:0] cnt;
        logic [FW-1:0] lim;
        logic          flag;
    } chan_state_t;

    localparam logic [FW-1:0] ONE = FW'(1);

    chan_state_t s_d, s_q;
    logic [FW:0] inc_d;
    logic        active_d;
    logic        wrap_d;

    always_comb begin
        s_d      = s_q;
        active_d = (s_q.lim != '0);
        inc_d    = {1'b0, s_q.cnt} + {{FW{1'b0}}, 1'b1};
        wrap_d   = tick && active_d && (inc_d >= {1'b0, s_q.lim});
        if (wr_lim) begin
            s_d.cnt  = ONE;
            s_d.flag = 1'b0;
        end else begin
            if (tick && active_d)
                s_d.cnt = wrap_d ? ONE : inc_d[FW-1:0];
            if (wrap_d)
                s_d.flag = 1'b1;
            else if (rd_lim)
                s_d.flag = 1'b0;
        end
        if (wr_lim || wr_keep)
            s_d.lim = wr_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= ONE;
            s_q.lim  <= RST_LIM;
            s_q.flag <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o  = s_q.cnt;
    assign lim_o  = s_q.lim;
    assign flag_o = s_q.flag;

    // R8: a zero limit freezes the count
    assert_zero_limit_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lim == '0 && !wr_lim && !wr_keep) |=> $stable(s_q.cnt));
    // R8: a zero limit never raises the flag
    assert_zero_limit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lim == '0 && !s_q.flag && !wr_lim && !wr_keep) |=> !s_q.flag);
    // R6: a normal limit write restarts the counter and drops the flag
    assert_limit_write_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lim |=> (s_q.cnt == ONE && !s_q.flag && s_q.lim == $past(wr_val)));
    // R7: a keep-count write without a tick leaves count and flag alone
    assert_keep_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_keep && !wr_lim && !tick) |=> ($stable(s_q.cnt) && $stable(s_q.flag)));
    // R3: a wrap lands on 1 with the flag set
    assert_wrap_to_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.lim != '0 && s_q.cnt >= s_q.lim - ONE && !wr_lim) |=>
        (s_q.cnt == ONE && s_q.flag));
    // R5: a limit read with no wrap clears the flag
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lim && !tick) |=> !s_q.flag);
    // R3: the counter never shows zero
    always @(posedge clk) if (rst_n) assert_count_nonzero_R3: assert (s_q.cnt != '0);
endmodule

// File: rtl/itp_regbus.sv
module itp_regbus
    import itp_pkg::*;
#(
    parameter int FW = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NCH-1:0][FW-1:0]  ch_cnt,
    input  logic [NCH-1:0][FW-1:0]  ch_lim,
    input  logic [NCH-1:0]          ch_flag,
    output logic [NCH-1:0]          wr_lim,
    output logic [NCH-1:0]          wr_keep,
    output logic [NCH-1:0]          rd_lim,
    output logic [DATA_W-1:0]       rdata
);
    localparam int LSB = DATA_W - 1 - FW;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cfg;
    } misc_state_t;

    misc_state_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        wr_lim  = '0;
        wr_keep = '0;
        rd_lim  = '0;
        rdata   = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (sel && addr == ADDR_W'(ch * CH_STRIDE + OFS_LIMIT)) begin
                wr_lim[ch] = wr;
                rd_lim[ch] = !wr;
                rdata      = {ch_flag[ch], ch_lim[ch], {LSB{1'b0}}};
            end
            if (sel && addr == ADDR_W'(ch * CH_STRIDE + OFS_KEEP))
                wr_keep[ch] = wr;
            if (sel && addr == ADDR_W'(ch * CH_STRIDE + OFS_COUNT))
                rdata = {ch_flag[ch], ch_cnt[ch], {LSB{1'b0}}};
        end
        if (sel && addr == ADDR_CTRL) begin
            rdata = m_q.ctrl;
            if (wr) m_d.ctrl = wdata;
        end
        if (sel && addr == ADDR_CFG) begin
            rdata = m_q.cfg;
            if (wr) m_d.cfg = wdata;
        end
        if (!sel || wr)
            rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    // R9: at most one channel strobe per access
    always_comb if (rst_n) assert_one_strobe_R9: assert ($onehot0({wr_lim, wr_keep, rd_lim}));
    // R10: control word stores what was written
    assert_ctrl_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && addr == ADDR_CTRL) |=> (m_q.ctrl == $past(wdata)));
    // R10: config word changes only by a write to its address
    assert_cfg_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr && addr == ADDR_CFG) |=> $stable(m_q.cfg));
endmodule

// File: rtl/interval_timer_pair.sv
module interval_timer_pair
    import itp_pkg::*;
#(
    parameter int FIELD_W = 21,
    parameter logic [FIELD_W-1:0] L14_RST_LIM = FIELD_W'(10000)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_us,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_l10,
    output logic        irq_l14
);
    localparam int LSB = DATA_W - 1 - FIELD_W;

    logic [NCH-1:0][FIELD_W-1:0] ch_cnt;
    logic [NCH-1:0][FIELD_W-1:0] ch_lim;
    logic [NCH-1:0]              ch_flag;
    logic [NCH-1:0]              wr_lim;
    logic [NCH-1:0]              wr_keep;
    logic [NCH-1:0]              rd_lim;

    itp_regbus #(.FW(FIELD_W)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .ch_cnt  (ch_cnt),
        .ch_lim  (ch_lim),
        .ch_flag (ch_flag),
        .wr_lim  (wr_lim),
        .wr_keep (wr_keep),
        .rd_lim  (rd_lim),
        .rdata   (bus_rdata)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic [FIELD_W-1:0] RL = (g == NCH - 1) ? L14_RST_LIM : '0;
        itp_channel #(.FW(FIELD_W), .RST_LIM(RL)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick_us),
            .wr_lim  (wr_lim[g]),
            .wr_keep (wr_keep[g]),
            .rd_lim  (rd_lim[g]),
            .wr_val  (bus_wdata[DATA_W-2:LSB]),
            .cnt_o   (ch_cnt[g]),
            .lim_o   (ch_lim[g]),
            .flag_o  (ch_flag[g])
        );
    end

    assign irq_l10 = ch_flag[0];
    assign irq_l14 = ch_flag[NCH-1];

    // R9: a limit write on one channel leaves the other channel's limit alone
    assert_lim_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lim[0] && !wr_keep[1]) |=> $stable(ch_lim[1]));
endmodule

// File: tb/test_interval_timer_pair.sv
module test_interval_timer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_l10, irq_l14;

    int checks = 0;
    int errors = 0;

    int unsigned m_cnt [2];
    int unsigned m_lim [2];
    bit          m_flg [2];
    logic [31:0] m_ctrl, m_cfg;

    always #5 clk = ~clk;

    interval_timer_pair i_interval_timer_pair (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_l10(irq_l10), .irq_l14(irq_l14)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] w;
        w = '0;
        case (a)
            3'd0, 3'd3: w = {m_flg[a/3], m_lim[a/3][20:0], 10'b0};
            3'd1, 3'd4: w = {m_flg[a/3], m_cnt[a/3][20:0], 10'b0};
            3'd6:       w = m_ctrl;
            3'd7:       w = m_cfg;
            default:    w = '0;
        endcase
        return w;
    endfunction

    task automatic model_step(input logic tk, input logic sel, input logic wr,
                              input logic [2:0] a, input logic [31:0] wd);
        for (int ch = 0; ch < 2; ch++) begin
            bit act, wrap, wl, wk, rl;
            act  = (m_lim[ch] != 0);
            wrap = tk && act && (m_cnt[ch] + 1 >= m_lim[ch]);
            wl   = sel && wr && (a == 3'(ch * 3));
            wk   = sel && wr && (a == 3'(ch * 3 + 2));
            rl   = sel && !wr && (a == 3'(ch * 3));
            if (wl) begin
                m_cnt[ch] = 1;
                m_flg[ch] = 0;
            end else begin
                if (tk && act) m_cnt[ch] = wrap ? 1 : m_cnt[ch] + 1;
                if (wrap) m_flg[ch] = 1;
                else if (rl) m_flg[ch] = 0;
            end
            if (wl || wk) m_lim[ch] = int'(wd[30:10]);
        end
        if (sel && wr && a == 3'd6) m_ctrl = wd;
        if (sel && wr && a == 3'd7) m_cfg = wd;
    endtask

    task automatic cyc(input string tag, input logic tk, input logic sel, input logic wr,
                       input logic [2:0] a, input logic [31:0] wd);
        @(negedge clk);
        tick_us   = tk;
        bus_sel   = sel;
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = wd;
        #1;
        chk({tag, " R9 irq_l10"}, {31'b0, irq_l10}, {31'b0, m_flg[0]});
        chk({tag, " R9 irq_l14"}, {31'b0, irq_l14}, {31'b0, m_flg[1]});
        if (sel && !wr) chk(tag, bus_rdata, exp_read(a));
        model_step(tk, sel, wr, a, wd);
    endtask

    task automatic wr_reg(input string tag, input logic [2:0] a, input logic [31:0] wd, input logic tk);
        cyc(tag, tk, 1'b1, 1'b1, a, wd);
    endtask

    task automatic rd_reg(input string tag, input logic [2:0] a, input logic tk);
        cyc(tag, tk, 1'b1, 1'b0, a, 32'h0);
    endtask

    function automatic logic [31:0] lim_word(input int n);
        return {1'b0, 21'(n), 10'b0};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        m_cnt = '{1, 1};
        m_lim = '{0, 10000};
        m_flg = '{0, 0};
        m_ctrl = '0;
        m_cfg  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_reg("R1 l10 limit", 3'd0, 1'b0);
        chk("R1 l14 limit literal", exp_read(3'd3), 32'h009C4000);
        rd_reg("R1 l14 limit", 3'd3, 1'b0);
        rd_reg("R1 l10 count", 3'd1, 1'b0);
        chk("R1 count literal", exp_read(3'd4), 32'h00000400);
        rd_reg("R1 l14 count", 3'd4, 1'b0);
        rd_reg("R1 ctrl", 3'd6, 1'b0);
        rd_reg("R1 cfg", 3'd7, 1'b0);

        // R8: zero limit holds channel 0 under ticks
        for (int i = 0; i < 6; i++) rd_reg("R8 zero limit count", 3'd1, 1'b1);

        // R4: bit 31 and bits 9:0 of a written limit are dropped
        wr_reg("R4 write", 3'd0, 32'hFFFF_FFFF, 1'b0);
        rd_reg("R4 limit read", 3'd0, 1'b0);
        chk("R4 limit literal", exp_read(3'd0), 32'h7FFF_FC00);
        rd_reg("R4 count read", 3'd1, 1'b0);

        // R2 R3 R5 R6: sweep limits and tick patterns on both channels
        for (int ch = 0; ch < 2; ch++) begin
            for (int lim = 1; lim <= 8; lim++) begin
                for (int p = 1; p <= 3; p++) begin
                    wr_reg("R6 limit write", 3'(ch * 3), lim_word(lim) | 32'h8000_03FF, 1'b1);
                    rd_reg("R6 count after write", 3'(ch * 3 + 1), 1'b0);
                    for (int i = 0; i < 3 * lim * p + 4; i++) begin
                        if (i % 4 == 3)
                            rd_reg("R5 limit read", 3'(ch * 3), 1'(i % p == 0));
                        else
                            rd_reg("R2 R3 count read", 3'(ch * 3 + 1), 1'(i % p == 0));
                    end
                end
            end
        end

        // R3: period check, limit 5 gives a flag after 4 ticks
        wr_reg("R3 period setup", 3'd0, lim_word(5), 1'b0);
        for (int i = 0; i < 4; i++) rd_reg("R3 period count", 3'd1, 1'b1);
        chk("R3 period flag", {31'b0, m_flg[0]}, 32'd1);
        rd_reg("R3 period wrapped", 3'd1, 1'b0);

        // R7: keep-count limit writes
        wr_reg("R7 setup", 3'd0, lim_word(10), 1'b0);
        for (int i = 0; i < 4; i++) rd_reg("R7 run", 3'd1, 1'b1);
        wr_reg("R7 keep raise", 3'd2, lim_word(20), 1'b1);
        rd_reg("R7 count kept", 3'd1, 1'b0);
        chk("R7 count literal", exp_read(3'd1), {1'b0, 21'd6, 10'b0});
        wr_reg("R7 keep lower", 3'd2, lim_word(3), 1'b0);
        rd_reg("R7 wrap below", 3'd1, 1'b1);
        chk("R7 flag after lower", {31'b0, m_flg[0]}, 32'd1);
        wr_reg("R7 keep flag", 3'd2, lim_word(30), 1'b0);
        rd_reg("R7 flag kept", 3'd1, 1'b0);
        rd_reg("R5 clear", 3'd0, 1'b0);
        rd_reg("R5 cleared", 3'd1, 1'b0);

        // R8: zero limit by write stops channel 1
        wr_reg("R8 zero write", 3'd3, 32'h0, 1'b0);
        for (int i = 0; i < 5; i++) rd_reg("R8 hold", 3'd4, 1'b1);

        // R10: control, config, count writes, keep-address reads
        wr_reg("R10 ctrl", 3'd6, 32'hA5A5_0001, 1'b0);
        wr_reg("R10 cfg", 3'd7, 32'h1234_5678, 1'b0);
        rd_reg("R10 ctrl read", 3'd6, 1'b0);
        rd_reg("R10 cfg read", 3'd7, 1'b0);
        wr_reg("R10 count write", 3'd1, 32'h7FFF_FFFF, 1'b0);
        rd_reg("R10 count unchanged", 3'd1, 1'b0);
        rd_reg("R10 keep read", 3'd2, 1'b0);
        rd_reg("R10 keep read l14", 3'd5, 1'b0);
        for (int i = 0; i < 4; i++) cyc("R2 idle", 1'b0, 1'b0, 1'b0, 3'd0, 32'h0);
        rd_reg("R2 hold without tick", 3'd1, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule